// File: doc/BRIEF.md
# Auxiliary UART Register and Interrupt Front-End

This block is the software-visible side of a small auxiliary UART. A host reads and writes 32-bit words at byte offsets inside a 256-byte window. Bytes coming from the serial receiver arrive on a valid/ready stream and are held in a circular receive queue. Software pops them by reading the data register. A byte written to the data register leaves at once as a single beat on a transmit stream, with no transmit buffer.

The transmit side is treated as permanently drained. An enabled transmit interrupt is therefore always pending. The receive interrupt is pending while the queue holds data and its enable is set. The block drives one level interrupt and a set of status words. Each status word is a fixed constant merged with the current queue state. Line control, modem control, modem status, scratch and baud registers are placeholders. They read zero and ignore writes, as does any other offset.

A register access lasts one cycle. Read data is combinational while `reg_rd` is high. Side effects such as pops, flushes and enable updates commit at the closing clock edge. A cycle with both `reg_rd` and `reg_wr` high counts as a write only.

Top module: `mini_uart_regs`

## Requirements
- R1: Synchronous active-high reset empties the receive queue, returns its read pointer to slot 0 and clears both interrupt enables. After reset `irq` is 0, `rx_ready` is 1, offset 0x44 reads 0xC0 and offset 0x64 reads 0x30E.
- R2: A write to offset 0x44 stores only bits 1:0. Bit 0 is the transmit enable and bit 1 is the receive enable. A read of 0x44 returns 0xC0 ORed with the stored bits.
- R3: `irq` is 1 exactly when the transmit enable is set, or when the receive enable is set and the queue is non-empty. Offset 0x00 reads 1 in that case and 0 otherwise.
- R4: Offset 0x48 reads 0xC0 ORed with 0x4 when the queue is non-empty (0x2 when it is empty), and ORed with 0x1 when no interrupt is pending.
- R5: A write to offset 0x48 with bit 1 set empties the queue in that cycle, and an input byte offered in the same cycle is dropped. A write with bit 1 clear changes nothing.
- R6: An input byte is accepted while the fill is below RX_DEPTH (8). It is stored at slot (read pointer + fill) mod RX_DEPTH, so bytes leave in arrival order across the wrap. `rx_ready` equals (fill < RX_DEPTH).
- R7: A read of offset 0x40 returns the byte at the read pointer. When the queue is non-empty, the same read then removes that byte and advances the pointer with wraparound.
- R8: A read of offset 0x40 on an empty queue returns the byte still held at the read pointer and changes neither the pointer nor the fill.
- R9: Offset 0x54 reads 0x60, with bit 0 set while the queue is non-empty. Offset 0x64 reads 0x30E; while the queue is non-empty, bit 0 is also set and the fill level sits in bits 16 and up.
- R10: Offset 0x04 always reads 1 and offset 0x60 always reads 3.
- R11: A write to offset 0x40 raises `tx_valid` for exactly the following cycle, with `tx_data` equal to bits 7:0 of the written word. Back-to-back writes give back-to-back beats.
- R12: Reads of offsets 0x4C, 0x50, 0x58, 0x5C, 0x68, any other unlisted offset or any offset with bits 1:0 non-zero return 0. Writes to them change no state and emit no transmit beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_addr | input | 8 | Byte offset in the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| rx_data | input | DATA_W (8) | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Queue can accept a byte |
| tx_data | output | DATA_W (8) | Outgoing byte |
| tx_valid | output | 1 | One-cycle outgoing beat |
| irq | output | 1 | Level interrupt |

## Verification
Read data is due in the same cycle as the read strobe, so the monitor compares it at the falling edge inside the access cycle. The pop, flush or enable change it causes is due only after the closing rising edge. A transmit beat is due exactly one cycle after the data-register write, and the monitor matches each beat against the queued expectation at the next falling edge. Any beat with no expectation counts as a miscompare, so a missing or repeated beat is caught. `irq` and `rx_ready` depend only on state, so they are checked one cycle after the stimulus that changes them, clear of the edge.

// File: rtl/muart_pkg.sv
package muart_pkg;

   localparam int BUS_W  = 32;
   localparam int ADDR_W = 8;

   // register offsets inside the 256-byte window
   localparam logic [ADDR_W-1:0] OFF_SUMMARY = 8'h00;
   localparam logic [ADDR_W-1:0] OFF_ENABLES = 8'h04;
   localparam logic [ADDR_W-1:0] OFF_DATA    = 8'h40;
   localparam logic [ADDR_W-1:0] OFF_IER     = 8'h44;
   localparam logic [ADDR_W-1:0] OFF_IIR     = 8'h48;
   localparam logic [ADDR_W-1:0] OFF_LSR     = 8'h54;
   localparam logic [ADDR_W-1:0] OFF_XCTL    = 8'h60;
   localparam logic [ADDR_W-1:0] OFF_XSTAT   = 8'h64;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_SUMMARY,
      SEL_ENABLES,
      SEL_DATA,
      SEL_IER,
      SEL_IIR,
      SEL_LSR,
      SEL_XCTL,
      SEL_XSTAT
   } reg_sel_e;

   // interrupt enable bit positions
   localparam int IE_TX_BIT     = 0;
   localparam int IE_RX_BIT     = 1;
   localparam int IIR_FLUSH_BIT = 1;

   // fixed parts of the status words
   localparam logic [BUS_W-1:0] ENABLES_VAL    = 32'h0000_0001;
   localparam logic [BUS_W-1:0] IER_FIXED      = 32'h0000_00C0;
   localparam logic [7:0]       IIR_FIXED      = 8'hC0;
   localparam logic [7:0]       IIR_RX_CAUSE   = 8'h04;
   localparam logic [7:0]       IIR_TX_CAUSE   = 8'h02;
   localparam logic [7:0]       IIR_NONE_PEND  = 8'h01;
   localparam logic [BUS_W-1:0] LSR_FIXED      = 32'h0000_0060;
   localparam logic [BUS_W-1:0] XCTL_VAL       = 32'h0000_0003;
   localparam logic [BUS_W-1:0] XSTAT_FIXED    = 32'h0000_030E;
   localparam int               XSTAT_FILL_LSB = 16;

endpackage

// File: rtl/muart_decode.sv
module muart_decode
   import muart_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   always_comb begin
      case (addr)
         OFF_SUMMARY: sel = SEL_SUMMARY;
         OFF_ENABLES: sel = SEL_ENABLES;
         OFF_DATA:    sel = SEL_DATA;
         OFF_IER:     sel = SEL_IER;
         OFF_IIR:     sel = SEL_IIR;
         OFF_LSR:     sel = SEL_LSR;
         OFF_XCTL:    sel = SEL_XCTL;
         OFF_XSTAT:   sel = SEL_XSTAT;
         // placeholder registers, unknown and misaligned offsets
         default:     sel = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/muart_rx_ring.sv
module muart_rx_ring #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 8,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   output logic              push_ready,
   input  logic              pop,
   input  logic              flush,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  fill,
   output logic              nonempty
);

   localparam int  PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit  IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (CNT_W != $clog2(DEPTH + 1)) begin : g_cnt_w_bad
      $error("muart_rx_ring: CNT_W must equal clog2(DEPTH+1)");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr;
   logic [PTR_W-1:0]  rd_next;
   logic [PTR_W-1:0]  wr_slot;
   logic [CNT_W-1:0]  cnt;
   logic              accept;
   logic              take;

   assign push_ready = (cnt < CNT_W'(DEPTH));
   assign nonempty   = (cnt != '0);
   assign fill       = cnt;
   assign head       = mem[rd_ptr];
   assign accept     = push_valid & push_ready & ~flush;
   assign take       = pop & nonempty & ~flush;

   if (IS_POW2) begin : g_pow2_wrap
      // natural overflow of the pointer does the modulo
      assign wr_slot = rd_ptr + cnt[PTR_W-1:0];
      assign rd_next = rd_ptr + 1'b1;
   end else begin : g_mod_wrap
      logic [PTR_W:0] slot_sum;
      assign slot_sum = {1'b0, rd_ptr} + {1'b0, cnt[PTR_W-1:0]};
      assign wr_slot  = (slot_sum >= (PTR_W+1)'(DEPTH))
                        ? PTR_W'(slot_sum - (PTR_W+1)'(DEPTH))
                        : slot_sum[PTR_W-1:0];
      assign rd_next  = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (flush) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + CNT_W'(accept) - CNT_W'(take);
         end
         if (take) begin
            rd_ptr <= rd_next;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         mem[wr_slot] <= push_data;
      end
   end

   // R6
   fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(DEPTH));

   // R6
   full_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (push_valid && !push_ready && !pop && !flush) |=> (cnt == $past(cnt)));

   // R7
   pop_step_chk: assert property (@(posedge clk) disable iff (rst)
      (pop && nonempty && !push_valid && !flush) |=> (cnt == $past(cnt) - 1'b1));

   // R8
   empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
      (pop && !nonempty && !push_valid && !flush) |=> (cnt == '0 && $stable(rd_ptr)));

   // R5
   flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
      flush |=> (cnt == '0));

endmodule

// File: rtl/muart_irq.sv
module muart_irq
   import muart_pkg::*;
(
   input  logic [1:0] ie,
   input  logic       rx_nonempty,
   output logic [1:0] pending,
   output logic       irq,
   output logic [7:0] iir_code
);

   always_comb begin
      pending            = '0;
      pending[IE_RX_BIT] = ie[IE_RX_BIT] & rx_nonempty;
      // transmit side is always drained, so an enabled TX cause is always live
      pending[IE_TX_BIT] = ie[IE_TX_BIT];
   end

   assign irq = (pending != '0);

   always_comb begin
      iir_code = IIR_FIXED;
      // receive cause reported in preference to transmit
      if (rx_nonempty) begin
         iir_code = iir_code | IIR_RX_CAUSE;
      end else begin
         iir_code = iir_code | IIR_TX_CAUSE;
      end
      if (!irq) begin
         iir_code = iir_code | IIR_NONE_PEND;
      end
   end

endmodule

// File: rtl/muart_rdmux.sv
module muart_rdmux
   import muart_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              rd_en,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] head,
   input  logic [1:0]        ie,
   input  logic [7:0]        iir_code,
   input  logic              irq,
   input  logic              nonempty,
   input  logic [CNT_W-1:0]  fill,
   output logic [BUS_W-1:0]  rdata
);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (sel)
            SEL_SUMMARY: rdata = {{(BUS_W-1){1'b0}}, irq};
            SEL_ENABLES: rdata = ENABLES_VAL;
            SEL_DATA:    rdata = BUS_W'(head);
            SEL_IER:     rdata = IER_FIXED | BUS_W'(ie);
            SEL_IIR:     rdata = BUS_W'(iir_code);
            SEL_LSR:     rdata = LSR_FIXED | BUS_W'(nonempty);
            SEL_XCTL:    rdata = XCTL_VAL;
            SEL_XSTAT:   rdata = XSTAT_FIXED | BUS_W'(nonempty)
                                 | (BUS_W'(fill) << XSTAT_FILL_LSB);
            default:     rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/mini_uart_regs.sv
module mini_uart_regs
   import muart_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int RX_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_valid,
   output logic              irq
);

   localparam int CNT_W = $clog2(RX_DEPTH + 1);

   if (DATA_W < 1 || DATA_W > 8) begin : g_data_w_bad
      $error("mini_uart_regs: DATA_W must be 1..8");
   end
   if (RX_DEPTH < 2 || CNT_W > (BUS_W - XSTAT_FILL_LSB)) begin : g_depth_bad
      $error("mini_uart_regs: RX_DEPTH out of range");
   end

   reg_sel_e          sel;
   logic              rd_en;
   logic              wr_data;
   logic              wr_ie;
   logic              flush;
   logic              pop;
   logic [1:0]        ie_q;
   logic              tx_valid_q;
   logic [DATA_W-1:0] tx_data_q;
   logic [DATA_W-1:0] head;
   logic [CNT_W-1:0]  fill;
   logic              nonempty;
   logic [1:0]        pending;
   logic [7:0]        iir_code;
   logic              unused_wbits;

   assign unused_wbits = ^reg_wdata[31:8];

   muart_decode u_decode (
      .addr (reg_addr),
      .sel  (sel)
   );

   // a cycle with both strobes counts as a write only
   assign rd_en   = reg_rd & ~reg_wr;
   assign wr_data = reg_wr & (sel == SEL_DATA);
   assign wr_ie   = reg_wr & (sel == SEL_IER);
   assign flush   = reg_wr & (sel == SEL_IIR) & reg_wdata[IIR_FLUSH_BIT];
   assign pop     = rd_en & (sel == SEL_DATA);

   always_ff @(posedge clk) begin
      if (rst) begin
         ie_q       <= '0;
         tx_valid_q <= 1'b0;
         tx_data_q  <= '0;
      end else begin
         if (wr_ie) begin
            ie_q <= reg_wdata[1:0];
         end
         tx_valid_q <= wr_data;
         if (wr_data) begin
            tx_data_q <= reg_wdata[DATA_W-1:0];
         end
      end
   end

   assign tx_valid = tx_valid_q;
   assign tx_data  = tx_data_q;

   muart_rx_ring #(
      .DEPTH  (RX_DEPTH),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_ring (
      .clk        (clk),
      .rst        (rst),
      .push_valid (rx_valid),
      .push_data  (rx_data),
      .push_ready (rx_ready),
      .pop        (pop),
      .flush      (flush),
      .head       (head),
      .fill       (fill),
      .nonempty   (nonempty)
   );

   muart_irq u_irq (
      .ie          (ie_q),
      .rx_nonempty (nonempty),
      .pending     (pending),
      .irq         (irq),
      .iir_code    (iir_code)
   );

   muart_rdmux #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_rdmux (
      .rd_en    (rd_en),
      .sel      (sel),
      .head     (head),
      .ie       (ie_q),
      .iir_code (iir_code),
      .irq      (irq),
      .nonempty (nonempty),
      .fill     (fill),
      .rdata    (reg_rdata)
   );

   // R3
   irq_tx_chk: assert property (@(posedge clk) disable iff (rst)
      ie_q[IE_TX_BIT] |-> irq);

   // R3
   irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (ie_q == 2'b00) |-> !irq);

   // R2
   ie_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_ie |=> $stable(ie_q));

   // R11
   tx_one_beat_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !wr_data) |=> !tx_valid);

endmodule

// File: tb/mini_uart_regs_bench.sv
`timescale 1ns/1ps
module mini_uart_regs_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        reg_rd;
   logic        reg_wr;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic [7:0]  rx_data;
   logic        rx_valid;
   logic        rx_ready;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        irq;

   always #2.5 clk = ~clk;

   mini_uart_regs u_mini_uart_regs (
      .clk       (clk),
      .rst       (rst),
      .reg_rd    (reg_rd),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .rx_ready  (rx_ready),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .irq       (irq)
   );

   typedef struct {
      logic [31:0] val;
      string       tag;
   } exp_t;

   exp_t rd_q[$];
   exp_t tx_q[$];
   exp_t mon_e;
   int   vectors     = 0;
   int   miscompares = 0;
   bit   finished    = 1'b0;

   task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // monitor: read data is due in the access cycle, a TX beat one cycle after the write
   always @(negedge clk) begin
      if (!rst) begin
         if (reg_rd && !reg_wr && rd_q.size() > 0) begin
            mon_e = rd_q.pop_front();
            compare(mon_e.tag, reg_rdata, mon_e.val);
         end
         if (tx_valid) begin
            if (tx_q.size() == 0) begin
               vectors++;
               miscompares++;
               $display("FAIL R11/R12 unexpected tx beat: actual 0x%02h expected none", tx_data);
            end else begin
               mon_e = tx_q.pop_front();
               compare(mon_e.tag, {24'b0, tx_data}, mon_e.val);
            end
         end
      end
   end

   task automatic go();
      @(posedge clk);
      #1;
      reg_rd   = 1'b0;
      reg_wr   = 1'b0;
      rx_valid = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      exp_t x;
      go();
      reg_rd   = 1'b1;
      reg_addr = a;
      x.val = e;
      x.tag = tag;
      rd_q.push_back(x);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      exp_t x;
      go();
      reg_wr    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      if (a == 8'h40) begin
         x.val = {24'b0, d[7:0]};
         x.tag = tag;
         tx_q.push_back(x);
      end
   endtask

   task automatic push(input logic [7:0] d, input logic exp_ready, input string tag);
      go();
      rx_valid = 1'b1;
      rx_data  = d;
      compare(tag, {31'b0, rx_ready}, {31'b0, exp_ready});
   endtask

   task automatic chk_irq(input logic e, input string tag);
      go();
      compare(tag, {31'b0, irq}, {31'b0, e});
   endtask

   task automatic do_reset();
      rst = 1'b1;
      go();
      go();
      rst = 1'b0;
   endtask

   initial begin
      #(100000 * 5);
      if (!finished) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
      rx_data = 0; rx_valid = 0;
      do_reset();

      // R1 reset state
      chk_irq(1'b0, "R1 irq after reset");
      compare("R1 rx_ready after reset", {31'b0, rx_ready}, 32'h1);
      rd(8'h44, 32'hC0, "R1 ier after reset");
      rd(8'h64, 32'h30E, "R1 xstat after reset");
      rd(8'h54, 32'h60, "R9 lsr empty");

      // R10 constants, R12 placeholders
      rd(8'h04, 32'h1, "R10 enables");
      rd(8'h60, 32'h3, "R10 extra control");
      rd(8'h4C, 32'h0, "R12 line control");
      rd(8'h58, 32'h0, "R12 modem status");
      rd(8'h80, 32'h0, "R12 unknown offset");
      rd(8'h41, 32'h0, "R12 misaligned data");

      // R2 / R3 / R4 interrupt enable behaviour
      wr(8'h44, 32'hFFFF_FFFF, "R2");
      rd(8'h44, 32'hC3, "R2 ier keeps two bits");
      chk_irq(1'b1, "R3 tx enable raises irq");
      rd(8'h00, 32'h1, "R3 summary pending");
      rd(8'h48, 32'hC2, "R4 iir empty pending");
      wr(8'h44, 32'h2, "R2");
      chk_irq(1'b0, "R3 rx enable empty queue");
      rd(8'h48, 32'hC3, "R4 iir nothing pending");
      rd(8'h00, 32'h0, "R3 summary idle");

      // R6 / R9 first byte
      push(8'hA5, 1'b1, "R6 ready with room");
      chk_irq(1'b1, "R3 rx data raises irq");
      rd(8'h48, 32'hC4, "R4 iir rx cause");
      rd(8'h54, 32'h61, "R9 lsr data");
      rd(8'h64, 32'h0001_030F, "R9 xstat fill 1");

      // fill to depth
      for (int i = 0; i < 7; i++) push(8'h10 + 8'(i), 1'b1, "R6 fill");
      push(8'h99, 1'b0, "R6 not ready when full");
      rd(8'h64, 32'h0008_030F, "R6 full byte refused");

      // R12 writes with no effect, R5 write without bit 1
      wr(8'h5C, 32'h2, "R12");
      wr(8'h4C, 32'h2, "R12");
      wr(8'h49, 32'h2, "R12");
      wr(8'h42, 32'h55, "R12 misaligned data write");
      wr(8'h48, 32'h1, "R5");
      rd(8'h64, 32'h0008_030F, "R5 R12 fill unchanged");

      // R7 pop order
      rd(8'h40, 32'hA5, "R7 pop first");
      for (int i = 0; i < 7; i++) rd(8'h40, 32'h10 + i, "R7 pop order");
      chk_irq(1'b0, "R3 irq drops when empty");
      rd(8'h64, 32'h30E, "R9 xstat empty");

      // R8 empty read: pointer wrapped to slot 0
      rd(8'h40, 32'hA5, "R8 stale byte");
      rd(8'h64, 32'h30E, "R8 fill unchanged");
      rd(8'h40, 32'hA5, "R8 pointer unchanged");

      // R6 / R7 wrap with offset pointer
      for (int i = 0; i < 5; i++) push(8'h31 + 8'(i), 1'b1, "R6 wrap fill");
      rd(8'h40, 32'h31, "R7 wrap pop");
      rd(8'h40, 32'h32, "R7 wrap pop");
      for (int i = 0; i < 5; i++) push(8'h36 + 8'(i), 1'b1, "R6 wrap fill");
      rd(8'h64, 32'h0008_030F, "R6 full after wrap");
      for (int i = 0; i < 8; i++) rd(8'h40, 32'h33 + i, "R6 R7 wrap order");

      // R5 flush
      push(8'h41, 1'b1, "R5 prefill");
      push(8'h42, 1'b1, "R5 prefill");
      wr(8'h48, 32'h6, "R5");
      chk_irq(1'b0, "R5 irq after flush");
      rd(8'h64, 32'h30E, "R5 xstat after flush");
      rd(8'h54, 32'h60, "R5 lsr after flush");
      push(8'h50, 1'b1, "R5 ready after flush");
      rd(8'h40, 32'h50, "R5 R7 byte after flush");

      // R11 transmit beats
      wr(8'h40, 32'h1234_5678, "R11 low byte");
      go(); go();
      wr(8'h40, 32'hAB, "R11 back to back");
      wr(8'h40, 32'hCD, "R11 back to back");
      go(); go();
      rd(8'h44, 32'hC2, "R11 ier untouched");

      // R1 reset from busy state
      wr(8'h44, 32'h3, "R1");
      push(8'h77, 1'b1, "R1 prefill");
      do_reset();
      chk_irq(1'b0, "R1 irq after second reset");
      rd(8'h44, 32'hC0, "R1 ier cleared");
      rd(8'h64, 32'h30E, "R1 queue emptied");
      go(); go();

      if (tx_q.size() != 0) begin
         vectors++;
         miscompares++;
         $display("FAIL R11 missing tx beats: actual %0d pending expected 0", tx_q.size());
      end
      if (rd_q.size() != 0) begin
         vectors++;
         miscompares++;
         $display("FAIL R12 unchecked reads: actual %0d pending expected 0", rd_q.size());
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule